// File: doc/BRIEF.md
# Serial Interrupt Host Controller

This block is the host end of a single-wire serialized interrupt bus. The wire is open-drain and wired-OR, and it is clocked by the bus clock. Each bus cycle opens with a Start Frame. A fixed number of three-clock IRQ/Data frames follows. A peripheral that pulls the line low in a frame's sample clock reports its interrupt as asserted. The host closes every cycle with a Stop Frame. The low width of the Stop Frame chooses how the next cycle opens. In continuous mode the host issues the next Start Frame itself. In quiet mode the host waits until a peripheral pulls the line low, then finishes the Start Frame for it.

The assembled interrupt vector changes once per cycle, when the Stop Frame ends. Bit n of the vector carries IRQ n, which travels in serial period n+1. A mode-select input is taken at the moment the Stop Frame begins. The block leaves reset in continuous mode, so the first cycle always collects the default interrupt levels.

The FSM states are S_IDLE, S_START, S_SRECOV, S_FRAMES, S_STOP and S_PRECOV. Its transitions are:
- S_IDLE to S_START: taken at once in continuous mode. In quiet mode it is taken when the line is seen low.
- S_START to S_SRECOV: taken once the Start Frame has lasted START_LEN clocks.
- S_SRECOV to S_FRAMES: always taken after one clock.
- S_FRAMES to S_STOP: taken after the turnaround clock of the last frame.
- S_STOP to S_PRECOV: taken after two or three low clocks. The vector commits on this transition.
- S_PRECOV to S_IDLE: always taken after one clock.

Top module: `serirq_host`

## Requirements
- R1: While rst_n is low, sirq_oe is 0 and irq_vec is all zeros.
- R2: In continuous mode, including the first cycle after reset, the host drives the line low (sirq_oe=1, sirq_out=0) for START_LEN consecutive clocks (default 4) with no peripheral activity.
- R3: Call the last low clock of the Start Frame clock 0. The host drives the line high for one clock (clock 1). Serial period P (1..NFRAMES) is then sampled at clock 3P-1. If the line is low there, irq_vec bit P-1 is set in the committed vector, and a high line clears that bit.
- R4: irq_vec stays unchanged during a cycle. The new value appears in the clock after the last Stop Frame clock.
- R5: The Stop Frame starts right after the turnaround clock (3*NFRAMES+1) of the last frame. It is 2 low clocks if quiet_sel was 1 when it began, and 3 low clocks otherwise.
- R6: After the Stop Frame the host drives the line high for one clock, then releases it. No Start Frame begins before the second clock after that rising edge.
- R7: In quiet mode the host leaves the line released (sirq_oe=0) for as long as it stays high while idle.
- R8: In quiet mode, a low line seen while idle counts as the first Start Frame clock. The host then drives START_LEN-1 further low clocks, and the frames follow the timing of R3.
- R9: Each Stop Frame sets the mode of the next cycle: 2 clocks selects quiet and 3 clocks selects continuous.
- R10: The host never enables its driver during the IRQ/Data frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sirq_in | input | 1 | Sensed level of the shared interrupt line |
| sirq_out | output | 1 | Level driven when sirq_oe is 1 |
| sirq_oe | output | 1 | Driver enable for the line |
| quiet_sel | input | 1 | 1 requests quiet mode for the next cycle, 0 requests continuous |
| irq_vec | output | NFRAMES | Committed interrupt levels, bit n is IRQ n (1 = asserted) |

## Verification
The bench plays the peripherals. It pulls the line low in chosen sample clocks and starts quiet cycles after random idle gaps. It targets four corner cases:
- Frame offset: a design off by one clock would report the recovery clock of the frame, so the vector would shift or drop bits. Walking single-bit patterns on IRQ0 and IRQ16 expose this.
- Stop width: if the two-clock and three-clock widths were swapped, every later cycle would open with the wrong owner.
- Early restart: a host that restarted immediately would break the one-clock gap.
- Quiet handshake: a host that counted the peripheral's clock twice would produce a Start Frame of the wrong length.

Mid-cycle vector reads catch a design that updates bits as they arrive instead of once per cycle.

// File: rtl/serirq_pkg.sv
package serirq_pkg;

    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_START  = 3'd1,
        S_SRECOV = 3'd2,
        S_FRAMES = 3'd3,
        S_STOP   = 3'd4,
        S_PRECOV = 3'd5
    } host_state_t;

endpackage

// File: rtl/serirq_frame_ctr.sv
// Walks the IRQ/Data frames: phase 0 is the sample clock, 1 recovery, 2 turnaround.
module serirq_frame_ctr #(
    parameter int NFRAMES = 17,
    localparam int IDXW   = $clog2(NFRAMES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    output logic [IDXW-1:0] fidx,
    output logic            smp,
    output logic            last
);
    logic [1:0] phase_q;
    logic [IDXW-1:0] idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= 2'd0;
            idx_q   <= '0;
        end else if (!run) begin
            phase_q <= 2'd0;
            idx_q   <= '0;
        end else if (phase_q == 2'd2) begin
            phase_q <= 2'd0;
            idx_q   <= idx_q + 1'b1;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    assign fidx = idx_q;
    assign smp  = run && (phase_q == 2'd0);
    assign last = run && (phase_q == 2'd2) && (idx_q == IDXW'(NFRAMES - 1));

endmodule

// File: rtl/serirq_capture.sv
// Gathers sampled levels into a shadow and publishes them once per cycle.
module serirq_capture #(
    parameter int NFRAMES = 17,
    localparam int IDXW   = $clog2(NFRAMES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               smp,
    input  logic [IDXW-1:0]    fidx,
    input  logic               line_low,
    input  logic               commit,
    output logic [NFRAMES-1:0] vec
);
    logic [NFRAMES-1:0] shadow_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_q <= '0;
        end else if (smp) begin
            shadow_q[fidx] <= line_low;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec <= '0;
        end else if (commit) begin
            vec <= shadow_q;
        end
    end

endmodule

// File: rtl/serirq_host.sv
module serirq_host
    import serirq_pkg::*;
#(
    parameter int NFRAMES   = 17,
    parameter int START_LEN = 4,
    localparam int IDXW     = $clog2(NFRAMES),
    localparam int CW       = $clog2(START_LEN + 3)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sirq_in,
    output logic               sirq_out,
    output logic               sirq_oe,
    input  logic               quiet_sel,
    output logic [NFRAMES-1:0] irq_vec
);
    host_state_t state_q, state_n;
    logic [CW-1:0] cnt_q, cnt_n;
    logic          cont_q, cont_n;   // 1: host opens the next cycle
    logic          stop_q, stop_n;   // 1: short (quiet) Stop Frame
    logic          commit;
    logic          smp, last;
    logic [IDXW-1:0] fidx;

    serirq_frame_ctr #(.NFRAMES(NFRAMES)) u_frames (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (state_q == S_FRAMES),
        .fidx (fidx),
        .smp  (smp),
        .last (last)
    );

    serirq_capture #(.NFRAMES(NFRAMES)) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .smp     (smp),
        .fidx    (fidx),
        .line_low(!sirq_in),
        .commit  (commit),
        .vec     (irq_vec)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
            cont_q  <= 1'b1;
            stop_q  <= 1'b0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
            cont_q  <= cont_n;
            stop_q  <= stop_n;
        end
    end

    // Next-state logic
    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        cont_n  = cont_q;
        stop_n  = stop_q;
        commit  = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (cont_q) begin
                    state_n = S_START;
                    cnt_n   = '0;
                end else if (!sirq_in) begin
                    state_n = S_START;
                    cnt_n   = CW'(1);
                end
            end
            S_START: begin
                if (cnt_q == CW'(START_LEN - 1)) begin
                    state_n = S_SRECOV;
                end else begin
                    cnt_n = cnt_q + 1'b1;
                end
            end
            S_SRECOV: state_n = S_FRAMES;
            S_FRAMES: begin
                if (last) begin
                    state_n = S_STOP;
                    cnt_n   = '0;
                    stop_n  = quiet_sel;
                end
            end
            S_STOP: begin
                if (cnt_q == (stop_q ? CW'(1) : CW'(2))) begin
                    state_n = S_PRECOV;
                    commit  = 1'b1;
                    cont_n  = !stop_q;
                end else begin
                    cnt_n = cnt_q + 1'b1;
                end
            end
            S_PRECOV: state_n = S_IDLE;
            default:  state_n = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        sirq_oe  = 1'b0;
        sirq_out = 1'b1;
        unique case (state_q)
            S_START, S_STOP: begin
                sirq_oe  = 1'b1;
                sirq_out = 1'b0;
            end
            S_SRECOV, S_PRECOV: begin
                sirq_oe  = 1'b1;
                sirq_out = 1'b1;
            end
            default: begin
                sirq_oe  = 1'b0;
                sirq_out = 1'b1;
            end
        endcase
    end

    // Assertions
    always @(posedge clk) begin
        if (!rst_n) begin
            assert_tristate_in_reset_R1: assert (!sirq_oe && irq_vec == '0)
                else $error("driver or vector active in reset");
        end
    end

    assert_first_sample_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (smp && fidx == '0) |-> $past(state_q) == S_SRECOV);

    assert_vec_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_STOP) |=> $stable(irq_vec));

    assert_stop_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_PRECOV) |->
            ($past(state_q) == S_STOP && $past(state_q, 2) == S_STOP &&
             ($past(stop_q) ? ($past(state_q, 3) != S_STOP) : ($past(state_q, 3) == S_STOP))));

    assert_start_after_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_START && $past(state_q) != S_START) |-> $past(state_q) == S_IDLE);

    assert_quiet_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && !cont_q && sirq_in) |=> !sirq_oe);

    assert_no_drive_in_frames_R10: assert property (@(posedge clk) disable iff (!rst_n)
        smp |-> !sirq_oe);

endmodule

// File: tb/serirq_host_bench.sv
`timescale 1ns/1ps
module serirq_host_bench;
    localparam int NFRAMES   = 17;
    localparam int START_LEN = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dev_low = 1'b0;
    logic quiet_sel = 1'b0;
    logic sirq_out, sirq_oe, sirq_in;
    logic [NFRAMES-1:0] irq_vec;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    // Wired-OR line: low if the host drives low or any peripheral pulls low.
    assign sirq_in = !((sirq_oe && !sirq_out) || dev_low);

    serirq_host #(.NFRAMES(NFRAMES), .START_LEN(START_LEN)) u_serirq_host (
        .clk      (clk),
        .rst_n    (rst_n),
        .sirq_in  (sirq_in),
        .sirq_out (sirq_out),
        .sirq_oe  (sirq_oe),
        .quiet_sel(quiet_sel),
        .irq_vec  (irq_vec)
    );

    function automatic int exp_start_len(bit quiet);
        return quiet ? START_LEN - 1 : START_LEN;
    endfunction

    function automatic int exp_stop_len(bit quiet_next);
        return quiet_next ? 2 : 3;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit host_low();
        return sirq_oe && !sirq_out;
    endfunction

    // Runs one bus cycle; entry and exit at the negedge of a host-recovery slot.
    task automatic run_cycle(input logic [NFRAMES-1:0] v, input bit quiet,
                             input bit qnext, input int wait_n, input bit first);
        int n;
        bit drove;
        bit moved;
        logic [NFRAMES-1:0] old;
        quiet_sel = qnext;
        if (quiet) begin
            for (int k = 0; k < wait_n; k++) begin
                @(negedge clk);
                check(!sirq_oe, "R7", sirq_oe, 0);
            end
            @(negedge clk);
            check(!sirq_oe, "R7", sirq_oe, 0);
            dev_low = 1'b1;
            @(negedge clk);
            dev_low = 1'b0;
        end else begin
            if (!first) begin
                @(negedge clk);
                check(!sirq_oe, "R6", sirq_oe, 0);
            end
            @(negedge clk);
        end
        n = 0;
        while (host_low() && n < 20) begin
            n++;
            @(negedge clk);
        end
        check(n == exp_start_len(quiet), quiet ? "R8" : "R2", n, exp_start_len(quiet));
        check(sirq_oe && sirq_out, "R3", {sirq_oe, sirq_out}, 2'b11);
        old = irq_vec;
        drove = 1'b0;
        moved = 1'b0;
        for (int k = 2; k <= 3 * NFRAMES + 1; k++) begin
            @(negedge clk);
            dev_low = (((k - 2) % 3) == 0) ? v[(k - 2) / 3] : 1'b0;
            if (sirq_oe) drove = 1'b1;
            if (irq_vec != old) moved = 1'b1;
        end
        @(negedge clk);
        dev_low = 1'b0;
        check(!drove, "R10", drove, 0);
        n = 0;
        while (host_low() && n < 10) begin
            if (irq_vec != old) moved = 1'b1;
            n++;
            @(negedge clk);
        end
        check(!moved, "R4", moved, 0);
        check(n == exp_stop_len(qnext), qnext ? "R5 R9 quiet" : "R5 R9 continuous",
              n, exp_stop_len(qnext));
        check(sirq_oe && sirq_out, "R6", {sirq_oe, sirq_out}, 2'b11);
        check(irq_vec == v, "R3", irq_vec, v);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        bit quiet;
        bit qn;
        logic [NFRAMES-1:0] v;
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        check(!sirq_oe, "R1", sirq_oe, 0);
        check(irq_vec == '0, "R1", irq_vec, 0);
        rst_n = 1'b1;
        // First cycle after reset: continuous, host-started
        run_cycle(17'h0_0000, 1'b0, 1'b0, 0, 1'b1);
        quiet = 1'b0;
        run_cycle(17'h1_FFFF, quiet, 1'b1, 0, 1'b0);   // all asserted, next quiet
        quiet = 1'b1;
        run_cycle(17'h0_0001, quiet, 1'b1, 6, 1'b0);   // IRQ0 only, quiet start after gap
        run_cycle(17'h1_0000, quiet, 1'b0, 0, 1'b0);   // IRQ16 only, quiet start at once
        quiet = 1'b0;
        run_cycle(17'h0_2000, quiet, 1'b0, 0, 1'b0);   // IRQ13 alone
        for (int i = 0; i < 30; i++) begin
            v  = NFRAMES'($urandom);
            qn = 1'($urandom);
            run_cycle(v, quiet, qn, int'($urandom % 8), 1'b0);
            quiet = qn;
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule